// File: doc/BRIEF.md
# Register-Access Command Channel

This block gives a host a small register port for reaching registers inside an attached serial slave device. The host loads one command word that carries a direction flag, a halfword register address and write data. The channel turns that word into a single request toward a back-end port, which uses a request/acknowledge handshake. The host follows progress by polling a packed status word. This word shows the channel state code, a request-pending flag, a sync-idle flag, a software-set init-done flag and the last 16-bit read result.

A write command finishes by itself once the back end acknowledges it. A read command stops in a parking state and keeps its data visible until the host writes a release bit. A release write also frees a channel that was left parked because an earlier release was never issued. Commands are taken only while the channel is enabled and idle. Any other command write is dropped and does not disturb the transaction in progress.

Top module: `regacc_channel`

## Requirements
- R1: After reset the status word reads 0x0010_0000. The state code is 0, pending is 0, sync idle is 1, init done is 0 and the data field is 0. The back-end request is low.
- R2: An accepted command word drives the back-end fields as follows: bit 31 becomes the write flag, bits 30:16 become the 15-bit address and bits 15:0 become the write data.
- R3: Status bits 18:16 hold the state code: idle = 0, request = 2, wait-for-data = 4, parked read = 6. No other code ever appears.
- R4: A write goes from request (2) to wait-for-data (4) in the cycle after the acknowledge, then to idle (0) one cycle later, with no parking step.
- R5: A read goes 2 → 4 → 6 and stays at 6 for any number of cycles until a release, with its data in status bits 15:0.
- R6: A host write to select 1 with data bit 0 = 1 moves a parked channel (6) to idle in one cycle. This recovers a channel whose earlier release was missed. A release with bit 0 = 0, or a release in any other state, has no effect.
- R7: A command written while the state is not idle is dropped. The back-end address, data and direction stay unchanged and no new request starts.
- R8: The enable bit is written at select 2, data bit 0, and is 0 after reset. While it is 0, a command write at select 0 is dropped.
- R9: The init-done bit is written at select 3, data bit 0, and appears in status bit 21.
- R10: The back-end request stays high from the accepted command until the acknowledge. Status bit 19 (pending) is high and bit 20 (sync idle) is low during exactly that interval.
- R11: Status bits 15:0 change only when a read is acknowledged. They keep their value through a release and through later write transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_valid | input | 1 | Host register write strobe |
| hw_sel | input | 2 | Host register select: 0 command, 1 release, 2 enable, 3 init done |
| hw_data | input | 32 | Host write data |
| status_word | output | 32 | Packed channel status |
| be_req | output | 1 | Back-end request |
| be_write | output | 1 | Back-end direction, 1 = write |
| be_addr | output | 15 | Back-end halfword address |
| be_wdata | output | 16 | Back-end write data |
| be_ack | input | 1 | Back-end acknowledge |
| be_rdata | input | 16 | Back-end read data, sampled with the acknowledge |

## Verification
A host command can arrive in the same cycle as a state change caused by the back end. The sharpest case is a new command written in the cycle where a finished write moves from wait-for-data back to idle. The channel is not idle at that edge, so the bench expects the command to be dropped: the state reads 0 afterwards, no request is raised and the back-end address still shows the earlier write. The bench also issues a release and a second command while a request is outstanding, and then checks that the state code, the address and the read data are all unchanged.

// File: rtl/regacc_pkg.sv
package regacc_pkg;

   localparam int STATE_W = 3;

   typedef enum logic [STATE_W-1:0] {
      CH_IDLE  = 3'd0,
      CH_REQ   = 3'd2,
      CH_WDATA = 3'd4,
      CH_PARK  = 3'd6
   } chan_state_e;

   typedef enum logic [1:0] {
      HSEL_CMD    = 2'd0,
      HSEL_CLEAR  = 2'd1,
      HSEL_ENABLE = 2'd2,
      HSEL_INIT   = 2'd3
   } host_sel_e;

endpackage

// File: rtl/regacc_hostif.sv
module regacc_hostif
   import regacc_pkg::*;
#(
   parameter int CMD_W  = 32,
   parameter int ADDR_W = 15,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_valid,
   input  logic [1:0]        hw_sel,
   input  logic [CMD_W-1:0]  hw_data,
   input  logic              fsm_idle,
   output logic              cmd_fire,
   output logic              cmd_write,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [DATA_W-1:0] cmd_wdata,
   output logic              clr_fire,
   output logic              init_done
);

   localparam int WFLAG_POS = CMD_W - 1;
   localparam int ADDR_LSB  = DATA_W;

   host_sel_e sel;
   logic      chan_en;

   assign sel = host_sel_e'(hw_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_en   <= 1'b0;
         init_done <= 1'b0;
      end else if (hw_valid) begin
         if (sel == HSEL_ENABLE) chan_en   <= hw_data[0];
         if (sel == HSEL_INIT)   init_done <= hw_data[0];
      end
   end

   // a command is taken only when enabled and the channel sits in idle
   assign cmd_fire  = hw_valid && (sel == HSEL_CMD) && chan_en && fsm_idle;
   assign clr_fire  = hw_valid && (sel == HSEL_CLEAR) && hw_data[0];
   assign cmd_write = hw_data[WFLAG_POS];
   assign cmd_addr  = hw_data[ADDR_LSB +: ADDR_W];
   assign cmd_wdata = hw_data[DATA_W-1:0];

   generate
      if (CMD_W > ADDR_W + DATA_W + 1) begin : g_spare
         logic spare_unused;
         assign spare_unused = ^hw_data[CMD_W-2:ADDR_W+DATA_W];
      end
   endgenerate

endmodule

// File: rtl/regacc_fsm.sv
module regacc_fsm
   import regacc_pkg::*;
#(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_fire,
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   input  logic              clr_fire,
   input  logic              be_ack,
   input  logic [DATA_W-1:0] be_rdata,
   output chan_state_e       state,
   output logic              be_req,
   output logic              be_write,
   output logic [ADDR_W-1:0] be_addr,
   output logic [DATA_W-1:0] be_wdata,
   output logic [DATA_W-1:0] rd_data
);

   chan_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         CH_IDLE:  if (cmd_fire) state_d = CH_REQ;
         CH_REQ:   if (be_ack)   state_d = CH_WDATA;
         CH_WDATA: state_d = be_write ? CH_IDLE : CH_PARK;
         CH_PARK:  if (clr_fire) state_d = CH_IDLE;
         default:  state_d = CH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= CH_IDLE;
         be_write <= 1'b0;
         be_addr  <= '0;
         be_wdata <= '0;
         rd_data  <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == CH_IDLE && cmd_fire) begin
            be_write <= cmd_write;
            be_addr  <= cmd_addr;
            be_wdata <= cmd_wdata;
         end
         if (state_q == CH_REQ && be_ack && !be_write)
            rd_data <= be_rdata;
      end
   end

   assign state  = state_q;
   assign be_req = (state_q == CH_REQ);

endmodule

// File: rtl/regacc_status.sv
module regacc_status
   import regacc_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int STAT_W    = 32,
   parameter bit STATUS_FF = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  chan_state_e       state,
   input  logic              pending,
   input  logic              init_done,
   input  logic [DATA_W-1:0] rd_data,
   output logic [STAT_W-1:0] status_word
);

   localparam int ST_LSB   = DATA_W;
   localparam int PEND_POS = DATA_W + STATE_W;
   localparam int SYNC_POS = PEND_POS + 1;
   localparam int INIT_POS = PEND_POS + 2;

   logic [STAT_W-1:0] packed_w;

   always_comb begin
      packed_w                       = '0;
      packed_w[DATA_W-1:0]           = rd_data;
      packed_w[ST_LSB +: STATE_W]    = state;
      packed_w[PEND_POS]             = pending;
      packed_w[SYNC_POS]             = !pending;
      packed_w[INIT_POS]             = init_done;
   end

   generate
      if (STATUS_FF) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               status_word           <= '0;
               status_word[SYNC_POS] <= 1'b1;
            end else begin
               status_word <= packed_w;
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk  = clk ^ rst_n;
         assign status_word = packed_w;
      end
   endgenerate

endmodule

// File: rtl/regacc_channel.sv
module regacc_channel #(
   parameter int CMD_W     = 32,
   parameter int ADDR_W    = 15,
   parameter int DATA_W    = 16,
   parameter int STAT_W    = 32,
   parameter bit STATUS_FF = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_valid,
   input  logic [1:0]        hw_sel,
   input  logic [CMD_W-1:0]  hw_data,
   output logic [STAT_W-1:0] status_word,
   output logic              be_req,
   output logic              be_write,
   output logic [ADDR_W-1:0] be_addr,
   output logic [DATA_W-1:0] be_wdata,
   input  logic              be_ack,
   input  logic [DATA_W-1:0] be_rdata
);
   import regacc_pkg::*;

   generate
      if (CMD_W < ADDR_W + DATA_W + 1) begin : g_bad_cmd
         $error("command word too narrow for flag, address and data");
      end
      if (STAT_W < DATA_W + STATE_W + 3) begin : g_bad_stat
         $error("status word too narrow for its fields");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("address and data widths must be positive");
      end
   endgenerate

   logic              cmd_fire, cmd_write, clr_fire, init_done;
   logic [ADDR_W-1:0] cmd_addr;
   logic [DATA_W-1:0] cmd_wdata, rd_data;
   chan_state_e       fsm_state;

   regacc_hostif #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hostif (
      .clk       (clk),
      .rst_n     (rst_n),
      .hw_valid  (hw_valid),
      .hw_sel    (hw_sel),
      .hw_data   (hw_data),
      .fsm_idle  (fsm_state == CH_IDLE),
      .cmd_fire  (cmd_fire),
      .cmd_write (cmd_write),
      .cmd_addr  (cmd_addr),
      .cmd_wdata (cmd_wdata),
      .clr_fire  (clr_fire),
      .init_done (init_done)
   );

   regacc_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_fire  (cmd_fire),
      .cmd_write (cmd_write),
      .cmd_addr  (cmd_addr),
      .cmd_wdata (cmd_wdata),
      .clr_fire  (clr_fire),
      .be_ack    (be_ack),
      .be_rdata  (be_rdata),
      .state     (fsm_state),
      .be_req    (be_req),
      .be_write  (be_write),
      .be_addr   (be_addr),
      .be_wdata  (be_wdata),
      .rd_data   (rd_data)
   );

   regacc_status #(.DATA_W(DATA_W), .STAT_W(STAT_W), .STATUS_FF(STATUS_FF)) u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .state       (fsm_state),
      .pending     (be_req),
      .init_done   (init_done),
      .rd_data     (rd_data),
      .status_word (status_word)
   );

endmodule

// File: rtl/regacc_channel_chk.sv
module regacc_channel_chk #(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        st,
   input logic              clr_fire,
   input logic [DATA_W-1:0] rd_data,
   input logic              be_req,
   input logic              be_write,
   input logic [ADDR_W-1:0] be_addr,
   input logic [DATA_W-1:0] be_wdata,
   input logic              be_ack,
   input logic [DATA_W-1:0] be_rdata
);

   assert_legal_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      st == 3'd0 || st == 3'd2 || st == 3'd4 || st == 3'd6);

   assert_start_from_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(be_req) |-> $past(st) == 3'd0);

   assert_hold_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
      be_req && !be_ack |=> be_req && $stable(be_addr) && $stable(be_wdata) && $stable(be_write));

   assert_ack_advances_R4: assert property (@(posedge clk) disable iff (!rst_n)
      be_req && be_ack |=> st == 3'd4 && !be_req);

   assert_write_skips_park_R4: assert property (@(posedge clk) disable iff (!rst_n)
      st == 3'd4 && be_write |=> st == 3'd0);

   assert_read_parks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      st == 3'd4 && !be_write |=> st == 3'd6);

   assert_park_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      st == 3'd6 && !clr_fire |=> st == 3'd6 && $stable(rd_data));

   assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      st == 3'd6 && clr_fire |=> st == 3'd0);

   assert_read_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
      be_req && be_ack && !be_write |=> rd_data == $past(be_rdata));

   assert_write_keeps_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
      be_req && be_write |=> $stable(rd_data));

endmodule

bind regacc_channel regacc_channel_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .st       (fsm_state),
   .clr_fire (clr_fire),
   .rd_data  (rd_data),
   .be_req   (be_req),
   .be_write (be_write),
   .be_addr  (be_addr),
   .be_wdata (be_wdata),
   .be_ack   (be_ack),
   .be_rdata (be_rdata)
);

// File: tb/regacc_channel_test.sv
module regacc_channel_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hw_valid = 1'b0;
   logic [1:0]  hw_sel = 2'd0;
   logic [31:0] hw_data = '0;
   logic [31:0] status_word;
   logic        be_req, be_write;
   logic [14:0] be_addr;
   logic [15:0] be_wdata;
   logic        be_ack = 1'b0;
   logic [15:0] be_rdata = '0;

   int n_checks = 0;
   int n_errs   = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   regacc_channel uut (
      .clk(clk), .rst_n(rst_n), .hw_valid(hw_valid), .hw_sel(hw_sel), .hw_data(hw_data),
      .status_word(status_word), .be_req(be_req), .be_write(be_write), .be_addr(be_addr),
      .be_wdata(be_wdata), .be_ack(be_ack), .be_rdata(be_rdata)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] st_code();
      return {29'd0, status_word[18:16]};
   endfunction

   task automatic host_now(logic [1:0] sel, logic [31:0] data);
      hw_valid = 1'b1; hw_sel = sel; hw_data = data;
      @(negedge clk);
      hw_valid = 1'b0;
   endtask

   task automatic host_wr(logic [1:0] sel, logic [31:0] data);
      @(negedge clk);
      host_now(sel, data);
   endtask

   task automatic ack_pulse(logic [15:0] rd);
      @(negedge clk);
      be_ack = 1'b1; be_rdata = rd;
      @(negedge clk);
      be_ack = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 status in reset", status_word, 32'h0010_0000);
      chk("R1 request in reset", {31'd0, be_req}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 status after reset", status_word, 32'h0010_0000);
   endtask

   task automatic t_init();
      host_wr(2'd3, 32'd1);
      chk("R9 init done set", {31'd0, status_word[21]}, 32'd1);
      host_wr(2'd3, 32'd0);
      chk("R9 init done cleared", {31'd0, status_word[21]}, 32'd0);
   endtask

   task automatic t_disabled();
      host_wr(2'd0, {1'b1, 15'h0042, 16'h1111});
      chk("R8 disabled state", st_code(), 32'd0);
      chk("R8 disabled request", {31'd0, be_req}, 32'd0);
      host_wr(2'd2, 32'd1);
   endtask

   task automatic t_write();
      host_wr(2'd0, {1'b1, 15'h1234, 16'hBEEF});
      chk("R3 request code", st_code(), 32'd2);
      chk("R2 write flag", {31'd0, be_write}, 32'd1);
      chk("R2 address", {17'd0, be_addr}, 32'h1234);
      chk("R2 write data", {16'd0, be_wdata}, 32'hBEEF);
      chk("R10 pending/sync", {30'd0, status_word[20:19]}, 32'b01);
      repeat (3) @(negedge clk);
      chk("R10 request held", {31'd0, be_req}, 32'd1);
      ack_pulse(16'hDEAD);
      chk("R4 wait code", st_code(), 32'd4);
      chk("R10 sync idle after ack", {30'd0, status_word[20:19]}, 32'b10);
      @(negedge clk);
      chk("R4 write back to idle", st_code(), 32'd0);
      chk("R11 write leaves data", {16'd0, status_word[15:0]}, 32'd0);
   endtask

   task automatic t_read();
      host_wr(2'd0, {1'b0, 15'h0ABC, 16'h0});
      chk("R2 read flag", {31'd0, be_write}, 32'd0);
      ack_pulse(16'h5AA5);
      chk("R5 wait code", st_code(), 32'd4);
      @(negedge clk);
      chk("R5 parked code", st_code(), 32'd6);
      chk("R5 read data", {16'd0, status_word[15:0]}, 32'h5AA5);
      repeat (10) @(negedge clk);
      chk("R5 stays parked", st_code(), 32'd6);
      host_wr(2'd1, 32'd0);
      chk("R6 release bit0=0 ignored", st_code(), 32'd6);
      host_wr(2'd1, 32'd1);
      chk("R6 release to idle", st_code(), 32'd0);
      chk("R11 data after release", {16'd0, status_word[15:0]}, 32'h5AA5);
   endtask

   task automatic t_ignore();
      host_wr(2'd0, {1'b0, 15'h0111, 16'h0});
      host_wr(2'd0, {1'b1, 15'h7777, 16'hAAAA});
      chk("R7 address kept", {17'd0, be_addr}, 32'h0111);
      chk("R7 direction kept", {31'd0, be_write}, 32'd0);
      chk("R7 still requesting", st_code(), 32'd2);
      host_wr(2'd1, 32'd1);
      chk("R6 release in request ignored", st_code(), 32'd2);
      ack_pulse(16'h1357);
      @(negedge clk);
      host_wr(2'd0, {1'b1, 15'h0555, 16'h2222});
      chk("R7 parked ignores command", st_code(), 32'd6);
      chk("R7 no request while parked", {31'd0, be_req}, 32'd0);
      chk("R11 parked data", {16'd0, status_word[15:0]}, 32'h1357);
      host_wr(2'd1, 32'd1);
   endtask

   task automatic t_collide();
      host_wr(2'd0, {1'b1, 15'h0222, 16'h3333});
      ack_pulse(16'hFFFF);
      chk("R4 wait before collision", st_code(), 32'd4);
      host_now(2'd0, {1'b0, 15'h0333, 16'h0});
      chk("R7 collision state idle", st_code(), 32'd0);
      chk("R7 collision no request", {31'd0, be_req}, 32'd0);
      chk("R7 collision address kept", {17'd0, be_addr}, 32'h0222);
      chk("R11 write ack data ignored", {16'd0, status_word[15:0]}, 32'h1357);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_errs++;
         n_checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_init();
      t_disabled();
      t_write();
      t_read();
      t_ignore();
      t_collide();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

endmodule